// File: doc/BRIEF.md
# Inter-processor interrupt destination decoder

This block owns the 64-bit interrupt command register of one local interrupt controller. Software writes the register as two 32-bit words. A write to the upper word only stores it. A write to the lower word stores it and launches a message. The block turns the message into one delivery strobe for up to eight agents on the interrupt bus. The strobe carries a per-agent target bitmask together with the vector, the delivery mode, the polarity and the trigger mode.

The target bitmask comes from three inputs: the destination shorthand, the destination byte read in physical or logical mode, and a broadcast override for INIT asserts. An INIT deassert sends no interrupt. It raises a separate strobe that tells the selected agents to copy their own ID into their arbitration ID. Setting the interrupt inside the receiving agents and lowest-priority arbitration are handled elsewhere.

A four-state machine controls the timing:
- ST_IDLE waits for a launch.
- A lower-word write moves the machine to ST_RESOLVE from any state.
- From ST_RESOLVE with no new lower-word write, the machine registers the decoded message and goes to one of three places:
  - ST_SEND, the delivery strobe;
  - ST_ARBSYNC, the arbitration-ID strobe, for an INIT deassert;
  - ST_IDLE, for a reserved delivery mode.
- ST_SEND and ST_ARBSYNC last one cycle each and return to ST_IDLE, or to ST_RESOLVE if a lower-word write arrives.

Top module: `ipi_dest_decoder`

## Requirements
- R1: A write to the upper word stores it, and it reads back on `icr_hi_q` after the next clock edge. On its own it produces neither strobe. The destination byte is bits 31:24 of the upper word.
- R2: A write to the lower word stores it, and it reads back on `icr_lo_q` after the next edge. If the write was sampled at edge k and no lower-word write occurs at edge k+1, exactly one strobe is high for the single cycle after edge k+1. The delivery strobe carries these fields from the lower word:
  - vector: bits 7:0;
  - delivery mode: bits 10:8;
  - polarity: bit 14 (the level bit);
  - trigger: bit 15.
- R3: Shorthand 0 (bits 19:18) with bit 11 = 0 is physical mode. Destination 0xFF selects every agent. Any other value selects only the agent whose index equals it, and an out-of-range value gives an empty mask that is still strobed.
- R4: Shorthand 0 with bit 11 = 1 is logical mode. Agent i is selected when the destination AND its logical-destination byte (bits 8i+7:8i of `agent_ldest`) is nonzero.
- R5: Shorthand 1 selects only the agent whose index equals `self_id`. Shorthand 2 selects all agents. Shorthand 3 selects all agents except `self_id`; if `self_id` matches no agent, shorthand 3 selects all agents.
- R6: Delivery mode 5 (INIT) that is not a deassert is delivered to every agent, whatever the shorthand and destination.
- R7: INIT with bit 14 = 0 and bit 15 = 1 is a deassert. It produces no delivery strobe. Instead `arb_sync_valid` is high for one cycle, at the R2 timing, with the shorthand/destination mask on `arb_sync_mask`.
- R8: Delivery mode 3 is reserved and produces neither strobe. Modes 0, 1, 2, 4, 6 and 7 are delivered with the decoded mask.
- R9: A second lower-word write sampled one edge after a launch replaces that launch. Only the later message is strobed, one cycle after the second write is resolved.
- R10: After reset both register words read zero and neither strobe is high.
- R11: When both words are written at the same edge, the message uses the newly written upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icr_hi_we | input | 1 | Upper-word write enable |
| icr_hi_wdata | input | 32 | Upper-word write data |
| icr_lo_we | input | 1 | Lower-word write enable (launches a message) |
| icr_lo_wdata | input | 32 | Lower-word write data |
| self_id | input | 8 | ID of the sending agent |
| agent_ldest | input | 64 | Logical-destination byte of each agent, agent i at bits 8i+7:8i |
| icr_lo_q | output | 32 | Stored lower word |
| icr_hi_q | output | 32 | Stored upper word |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_mask | output | 8 | Target agents of the delivery |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered delivery mode |
| dlv_polarity | output | 1 | Delivered polarity (level bit) |
| dlv_trigger | output | 1 | Delivered trigger mode |
| arb_sync_valid | output | 1 | One-cycle strobe to load arbitration IDs |
| arb_sync_mask | output | 8 | Agents that load their arbitration ID |

## Verification
Errors in the machine's state show up at fixed times after a launch:
- A missed or extra transition out of ST_RESOLVE shows as a missing, doubled or misplaced strobe exactly two edges after the launching write.
- Taking the wrong branch shows as the delivery strobe appearing where the arbitration strobe belongs, or the reverse.
- A bad decode of shorthand, mode or destination appears on the mask in that same strobe cycle.

A corrupted command word shows on the readback ports one edge after the write. A comparison on every clock against a behavioural model therefore localises any fault to within one cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W    = 32;
    localparam int VEC_W     = 8;
    localparam int DEST_W    = 8;
    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int LOGIC_BIT = 11;
    localparam int LEVEL_BIT = 14;
    localparam int TRIG_BIT  = 15;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = 24;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'd0,
        DM_LOWEST  = 3'd1,
        DM_SMI     = 3'd2,
        DM_RSVD    = 3'd3,
        DM_NMI     = 3'd4,
        DM_INIT    = 3'd5,
        DM_STARTUP = 3'd6,
        DM_EXTINT  = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_SEND,
        ST_ARBSYNC
    } cmd_state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        dlv_mode_e        mode;
        logic             logical;
        logic             level;
        logic             trigger;
        shorthand_e       shorthand;
    } cmd_fields_t;

    function automatic cmd_fields_t split_low_word(input logic [WORD_W-1:0] w);
        cmd_fields_t f;
        f.vector    = w[VEC_LSB +: VEC_W];
        f.mode      = dlv_mode_e'(w[MODE_LSB +: 3]);
        f.logical   = w[LOGIC_BIT];
        f.level     = w[LEVEL_BIT];
        f.trigger   = w[TRIG_BIT];
        f.shorthand = shorthand_e'(w[SH_LSB +: 2]);
        return f;
    endfunction

    function automatic logic is_init_deassert(input cmd_fields_t f);
        return (f.mode == DM_INIT) && !f.level && f.trigger;
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [WORD_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [WORD_W-1:0] lo_wdata,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_we) begin
            hi_q <= hi_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (lo_we) begin
            lo_q <= lo_wdata;
        end
    end

endmodule

// File: rtl/ipi_target_gen.sv
module ipi_target_gen
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 8,
    parameter int ID_W     = 8,
    parameter int LD_W     = 8
) (
    input  logic [LD_W-1:0]          dest,
    input  logic                     logical_mode,
    input  shorthand_e               shorthand,
    input  logic                     force_all,
    input  logic [ID_W-1:0]          self_id,
    input  logic [N_AGENTS*LD_W-1:0] agent_ldest,
    output logic [N_AGENTS-1:0]      targets
);

    localparam logic [LD_W-1:0] DEST_BCAST = '1;

    logic [N_AGENTS-1:0] by_dest;
    logic [N_AGENTS-1:0] is_self;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        logic [LD_W-1:0] ld_byte;
        logic            phys_hit;
        logic            logic_hit;

        assign ld_byte    = agent_ldest[g*LD_W +: LD_W];
        assign phys_hit   = (dest == DEST_BCAST) || (dest == LD_W'(g));
        assign logic_hit  = |(dest & ld_byte);
        assign by_dest[g] = logical_mode ? logic_hit : phys_hit;
        assign is_self[g] = (self_id == ID_W'(g));
    end

    always_comb begin
        targets = '0;
        if (force_all) begin
            targets = '1;
        end else begin
            unique case (shorthand)
                SH_NONE:   targets = by_dest;
                SH_SELF:   targets = is_self;
                SH_ALL:    targets = '1;
                SH_OTHERS: targets = ~is_self;
                default:   targets = '0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_cmd_fsm.sv
module ipi_cmd_fsm
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  cmd_fields_t         fields,
    input  logic [N_AGENTS-1:0] targets,
    output logic                dlv_valid,
    output logic                arb_sync_valid,
    output logic [N_AGENTS-1:0] mask_q,
    output logic [VEC_W-1:0]    vector_q,
    output dlv_mode_e           mode_q,
    output logic                polarity_q,
    output logic                trigger_q
);

    cmd_state_e state_q;
    cmd_state_e state_d;
    logic       resolving;

    assign resolving = (state_q == ST_RESOLVE) && !launch;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = ST_RESOLVE;
            ST_RESOLVE: begin
                if (launch) begin
                    state_d = ST_RESOLVE;
                end else if (fields.mode == DM_RSVD) begin
                    state_d = ST_IDLE;
                end else if (is_init_deassert(fields)) begin
                    state_d = ST_ARBSYNC;
                end else begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND:    state_d = launch ? ST_RESOLVE : ST_IDLE;
            ST_ARBSYNC: state_d = launch ? ST_RESOLVE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            vector_q   <= '0;
            mode_q     <= DM_FIXED;
            polarity_q <= 1'b0;
            trigger_q  <= 1'b0;
        end else if (resolving) begin
            mask_q     <= targets;
            vector_q   <= fields.vector;
            mode_q     <= fields.mode;
            polarity_q <= fields.level;
            trigger_q  <= fields.trigger;
        end
    end

    assign dlv_valid      = (state_q == ST_SEND);
    assign arb_sync_valid = (state_q == ST_ARBSYNC);

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid);

    a_r2_strobe_timing: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ($past(launch, 2) && !$past(launch)));

    a_r7_sync_timing: assert property (@(posedge clk) disable iff (!rst_n)
        arb_sync_valid |-> ($past(launch, 2) && !$past(launch)));

    a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        arb_sync_valid |=> !arb_sync_valid);

    a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid || arb_sync_valid) |-> (mode_q != DM_RSVD));

endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 8,
    parameter int ID_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       icr_hi_we,
    input  logic [31:0]                icr_hi_wdata,
    input  logic                       icr_lo_we,
    input  logic [31:0]                icr_lo_wdata,
    input  logic [ID_W-1:0]            self_id,
    input  logic [N_AGENTS*DEST_W-1:0] agent_ldest,
    output logic [31:0]                icr_lo_q,
    output logic [31:0]                icr_hi_q,
    output logic                       dlv_valid,
    output logic [N_AGENTS-1:0]        dlv_mask,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [2:0]                 dlv_mode,
    output logic                       dlv_polarity,
    output logic                       dlv_trigger,
    output logic                       arb_sync_valid,
    output logic [N_AGENTS-1:0]        arb_sync_mask
);

    cmd_fields_t         fields;
    logic [N_AGENTS-1:0] targets;
    logic                force_all;
    dlv_mode_e           mode_q;
    logic [N_AGENTS-1:0] mask_q;

    ipi_cmd_regs #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (icr_hi_we),
        .hi_wdata (icr_hi_wdata),
        .lo_we    (icr_lo_we),
        .lo_wdata (icr_lo_wdata),
        .lo_q     (icr_lo_q),
        .hi_q     (icr_hi_q)
    );

    assign fields    = split_low_word(icr_lo_q);
    assign force_all = (fields.mode == DM_INIT) && !is_init_deassert(fields);

    ipi_target_gen #(
        .N_AGENTS (N_AGENTS),
        .ID_W     (ID_W),
        .LD_W     (DEST_W)
    ) u_targets (
        .dest         (icr_hi_q[DEST_LSB +: DEST_W]),
        .logical_mode (fields.logical),
        .shorthand    (fields.shorthand),
        .force_all    (force_all),
        .self_id      (self_id),
        .agent_ldest  (agent_ldest),
        .targets      (targets)
    );

    ipi_cmd_fsm #(.N_AGENTS(N_AGENTS)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch         (icr_lo_we),
        .fields         (fields),
        .targets        (targets),
        .dlv_valid      (dlv_valid),
        .arb_sync_valid (arb_sync_valid),
        .mask_q         (mask_q),
        .vector_q       (dlv_vector),
        .mode_q         (mode_q),
        .polarity_q     (dlv_polarity),
        .trigger_q      (dlv_trigger)
    );

    assign dlv_mode      = mode_q;
    assign dlv_mask      = mask_q;
    assign arb_sync_mask = mask_q;

    a_r2_payload: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_vector == icr_lo_q[7:0]) && (dlv_mode == icr_lo_q[10:8])
                      && (dlv_polarity == icr_lo_q[14]) && (dlv_trigger == icr_lo_q[15]));

    a_r6_init_everyone: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'd5) |-> (&dlv_mask));

    a_r5_others_skip_self: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && icr_lo_q[19:18] == 2'd3 && dlv_mode != 3'd5)
            |-> ((dlv_mask & (N_AGENTS'(1) << $past(self_id))) == '0));

    a_r3_phys_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && icr_lo_q[19:18] == 2'd0 && !icr_lo_q[11] && !$past(icr_hi_we)
            && icr_hi_q[31:24] == 8'hFF) |-> (&dlv_mask));

endmodule

// File: tb/tb_ipi_dest_decoder.sv
`timescale 1ns/1ps
module tb_ipi_dest_decoder;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0]   hi_wd = '0, lo_wd = '0;
    logic [7:0]    sid = '0;
    logic [7:0]    ld_b [N];
    logic [N*8-1:0] ld_flat;
    logic [31:0]   lo_q, hi_q;
    logic          dv, av;
    logic [N-1:0]  dmask, amask;
    logic [7:0]    dvec;
    logic [2:0]    dmode;
    logic          dpol, dtrig;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R10";

    always #2.5 clk = ~clk;

    always_comb begin
        for (int a = 0; a < N; a++) ld_flat[a*8 +: 8] = ld_b[a];
    end

    ipi_dest_decoder #(.N_AGENTS(N), .ID_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .icr_hi_we(hi_we), .icr_hi_wdata(hi_wd),
        .icr_lo_we(lo_we), .icr_lo_wdata(lo_wd),
        .self_id(sid), .agent_ldest(ld_flat),
        .icr_lo_q(lo_q), .icr_hi_q(hi_q),
        .dlv_valid(dv), .dlv_mask(dmask), .dlv_vector(dvec), .dlv_mode(dmode),
        .dlv_polarity(dpol), .dlv_trigger(dtrig),
        .arb_sync_valid(av), .arb_sync_mask(amask)
    );

    // behavioural reference
    logic [31:0]  m_lo = '0, m_hi = '0;
    bit           m_pend = 0;
    bit           e_dv = 0, e_av = 0;
    logic [N-1:0] e_mask = '0;
    logic [31:0]  e_lo = '0;

    function automatic logic [N-1:0] ref_targets(input logic [31:0] lo, input logic [31:0] hi,
                                                 input int self_i);
        logic [N-1:0] m = '0;
        int  mode = int'(lo[10:8]);
        int  dst  = int'(hi[31:24]);
        bit  deass = (mode == 5) && !lo[14] && lo[15];
        for (int a = 0; a < N; a++) begin
            case (int'(lo[19:18]))
                0: m[a] = lo[11] ? ((hi[31:24] & ld_b[a]) != 8'h00) : (dst == 255 || dst == a);
                1: m[a] = (a == self_i);
                2: m[a] = 1'b1;
                default: m[a] = (a != self_i);
            endcase
        end
        if (mode == 5 && !deass) m = '1;
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = '0; m_hi = '0; m_pend = 0; e_dv = 0; e_av = 0;
        end else begin
            e_dv = 0; e_av = 0;
            if (m_pend && !lo_we && m_lo[10:8] != 3'd3) begin
                e_mask = ref_targets(m_lo, m_hi, int'(sid));
                e_lo   = m_lo;
                if (m_lo[10:8] == 3'd5 && !m_lo[14] && m_lo[15]) e_av = 1;
                else e_dv = 1;
            end
            if (hi_we) m_hi = hi_wd;
            if (lo_we) m_lo = lo_wd;
            m_pend = lo_we;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("icr_lo", lo_q, m_lo);
            chk("icr_hi", hi_q, m_hi);
            chk("dlv_valid", 32'(dv), 32'(e_dv));
            chk("arb_sync_valid", 32'(av), 32'(e_av));
            if (e_dv) begin
                chk("dlv_mask", 32'(dmask), 32'(e_mask));
                chk("dlv_vector", 32'(dvec), 32'(e_lo[7:0]));
                chk("dlv_mode", 32'(dmode), 32'(e_lo[10:8]));
                chk("dlv_polarity", 32'(dpol), 32'(e_lo[14]));
                chk("dlv_trigger", 32'(dtrig), 32'(e_lo[15]));
            end
            if (e_av) chk("arb_sync_mask", 32'(amask), 32'(e_mask));
        end
    end

    task automatic wr(input bit he, input logic [31:0] h, input bit le, input logic [31:0] l);
        @(negedge clk);
        hi_we = he; hi_wd = h; lo_we = le; lo_wd = l;
        @(negedge clk);
        hi_we = 0; lo_we = 0;
    endtask

    task automatic send(input string req, input logic [31:0] h, input logic [31:0] l);
        cur_req = req;
        wr(1, h, 0, '0);
        wr(0, '0, 1, l);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < N; a++) ld_b[a] = 8'(1 << a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R10";
        repeat (3) @(negedge clk);
        // R1: upper word alone stores and never launches
        cur_req = "R1";
        wr(1, 32'h0300_0000, 0, '0);
        repeat (4) @(negedge clk);
        // R2 and R3: fixed, physical single agent
        send("R2", 32'h0300_0000, 32'h0000_C041);
        send("R3", 32'hFF00_0000, 32'h0000_4122);
        send("R3", 32'h0900_0000, 32'h0000_0433);
        // R4: logical matches
        send("R4", 32'h0C00_0000, 32'h0000_0855);
        ld_b[0] = 8'h80; ld_b[7] = 8'h01;
        send("R4", 32'h8100_0000, 32'h0000_0856);
        send("R4", 32'h0000_0000, 32'h0000_0857);
        // R5: shorthands
        sid = 8'd5;
        send("R5", 32'h0200_0000, 32'h0004_0266);
        send("R5", 32'h0200_0000, 32'h0008_0677);
        send("R5", 32'h0200_0000, 32'h000C_0788);
        sid = 8'd9;
        send("R5", 32'h0200_0000, 32'h000C_0789);
        sid = 8'd5;
        // R6: INIT assert reaches all
        send("R6", 32'h0200_0000, 32'h0004_4599);
        send("R6", 32'h0200_0000, 32'h0000_C59A);
        // R7: INIT deassert
        send("R7", 32'h0200_0000, 32'h0000_8500);
        send("R7", 32'h0200_0000, 32'h000C_8500);
        // R8: reserved mode, then the other modes
        send("R8", 32'hFF00_0000, 32'h0000_0300);
        send("R8", 32'hFF00_0000, 32'h0008_0111);
        send("R8", 32'h0100_0000, 32'h0000_0212);
        // R9: back-to-back lower writes
        cur_req = "R9";
        wr(1, 32'h0400_0000, 0, '0);
        @(negedge clk);
        hi_we = 0; lo_we = 1; lo_wd = 32'h0000_0066;
        @(negedge clk);
        lo_wd = 32'h0000_0477;
        @(negedge clk);
        lo_we = 0;
        repeat (4) @(negedge clk);
        // R11: both words written together
        cur_req = "R11";
        wr(1, 32'h0600_0000, 1, 32'h0000_0088);
        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            summary();
        end
    end

endmodule